// File: doc/BRIEF.md
# Dual-List Soft-Decision Candidate Decoder

This block is the search and output stage of a soft-decision decoder for a rate-1/2 systematic (32,16) block code. It receives a frame of 32 signed soft samples and, for each half of the word, the indices of the five least trustworthy positions. The hard decision of each sample is its sign. Two branches then run side by side. The first branch flips subsets of the unreliable message positions and re-encodes the result to a full codeword. The second branch flips subsets of the unreliable parity positions and maps them back to a message through the inverse of the encoder. Every candidate codeword gets a score against the received samples, and the lowest score is kept.

Each branch tries one pattern per clock, so the search takes 32 cycles. The 16 bits of the winning message then leave one per clock through a shift register. A new frame can be started as soon as the search ends, while the previous result is still shifting out. No hard-decision decoder and no matrix reduction are used. The encoder and its inverse are one parameterized mixing network built in a forward or an inverse variant.

Top module: `dual_list_softdec`

## Requirements
- R1: Sample i occupies bits [8i+7:8i] of `samples_i` as two's complement. Samples 0..15 are message bits 0..15 and samples 16..31 are parity bits 0..15. The hard decision is 1 for a negative sample and 0 otherwise.
- R2: A high `start_i` at a clock edge captures the samples and both index lists, but only when no search is running. A `start_i` during a search is ignored, and the result is that of the frame already captured.
- R3: Forward map (message to parity) is three mixing layers with a rotation between consecutive layers. A mixing layer maps the pair (x at position 2j, y at 2j+1) to (y, x XOR y). The rotation moves the bit at 4-bit index i to the index i rotated left by one. The systematic branch, at pattern p (0..31), XORs a one into message position `sys_lr_i[4j+3:4j]` for each set bit j of p, so that repeated indices cancel. It then applies the forward map.
- R4: The parity branch applies the same flip rule with `par_lr_i` to the parity hard decisions. It then recovers the message with the exact inverse map: an unmixing layer, then an inverse rotation and an unmixing layer, with that pair repeated until three unmixing layers are done. A pair (a, b) unmixes to (a XOR b, a).
- R5: The score of a candidate codeword is the sum of sample magnitudes over all 32 positions where it disagrees with the hard decision. The magnitude of -128 counts as 128. The sum never wraps.
- R6: The output is the candidate with the lowest score over all 64 candidates. In any one pattern, the systematic candidate is preferred when the two scores are equal. Across patterns, a later candidate replaces the kept one only when its score is strictly lower.
- R7: For a frame whose hard decisions form a codeword, the output is that codeword's message, which is also the exhaustive maximum-likelihood answer.
- R8: The first decoded bit is valid in the cycle after the 32nd rising edge that follows the capturing edge. `bit_vld_o` stays high for exactly 16 cycles, with message bit 0 first and bit 15 last.
- R9: During and after reset, and whenever `bit_vld_o` is low, `bit_o` is 0 and no search is running.
- R10: A frame started at the edge just after a search ends runs while the previous result shifts out. Neither result is disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture a frame and begin a search |
| samples_i | input | 256 | 32 signed 8-bit soft samples |
| sys_lr_i | input | 20 | Five 4-bit indices of unreliable message positions |
| par_lr_i | input | 20 | Five 4-bit indices of unreliable parity positions |
| bit_o | output | 1 | Decoded message bit, serial |
| bit_vld_o | output | 1 | `bit_o` carries a decoded bit |

## Verification
In every search cycle, the systematic and parity candidates of the same pattern are scored together. When their scores are equal, the preference rule has to pick the systematic one. The bench provokes this with frames whose samples all have magnitude one, so the score reduces to a Hamming distance and equal scores between different codewords are common. It also provokes it with frames where every magnitude is 128. The result is judged against a bench model of the 64-candidate search with the stated preference order, together with noiseless frames checked against an exhaustive search over all 65536 codewords.

// File: rtl/sdec_pkg.sv
package sdec_pkg;
  localparam int unsigned SD_K   = 16;  // message length (half of the word)
  localparam int unsigned SD_Q   = 8;   // soft sample width
  localparam int unsigned SD_NLR = 5;   // unreliable positions searched per half
  localparam int unsigned SD_NST = 3;   // mixing layers in the code map

  // index rotated left by one inside an lk-bit field
  function automatic int rotl1(int i, int lk);
    return ((i << 1) | (i >> (lk - 1))) & ((1 << lk) - 1);
  endfunction
endpackage

// File: rtl/sdec_code_map.sv
module sdec_code_map #(
  parameter int unsigned K   = 16,
  parameter int unsigned NST = 3,
  parameter bit          INV = 1'b0
) (
  input  logic [K-1:0] in_i,
  output logic [K-1:0] out_o
);
  localparam int LK = $clog2(K);

  logic [K-1:0] st [NST+1];
  assign st[0] = in_i;

  for (genvar s = 0; s < NST; s++) begin : g_layer
    logic [K-1:0] a, b;
    if (!INV) begin : g_fwd
      // mix pairs, then rotate unless this is the last layer
      for (genvar j = 0; j < K/2; j++) begin : g_mix
        assign a[2*j]   = st[s][2*j+1];
        assign a[2*j+1] = st[s][2*j] ^ st[s][2*j+1];
      end
      if (s < NST-1) begin : g_rot
        for (genvar i = 0; i < K; i++) begin : g_b
          localparam int D = sdec_pkg::rotl1(i, LK);
          assign b[D] = a[i];
        end
      end else begin : g_norot
        assign b = a;
      end
    end else begin : g_inv
      // undo rotation (not before the first layer), then unmix
      if (s > 0) begin : g_unrot
        for (genvar i = 0; i < K; i++) begin : g_b
          localparam int D = sdec_pkg::rotl1(i, LK);
          assign a[i] = st[s][D];
        end
      end else begin : g_nounrot
        assign a = st[s];
      end
      for (genvar j = 0; j < K/2; j++) begin : g_unmix
        assign b[2*j]   = a[2*j] ^ a[2*j+1];
        assign b[2*j+1] = a[2*j];
      end
    end
    assign st[s+1] = b;
  end

  assign out_o = st[NST];
endmodule

// File: rtl/sdec_flip.sv
module sdec_flip #(
  parameter int unsigned K   = 16,
  parameter int unsigned NLR = 5,
  parameter int unsigned IW  = 4
) (
  input  logic [K-1:0]      base_i,
  input  logic [NLR*IW-1:0] idx_i,
  input  logic [NLR-1:0]    pat_i,
  output logic [K-1:0]      out_o
);
  logic [K-1:0] mask;

  always_comb begin
    mask = '0;
    for (int j = 0; j < NLR; j++) begin
      if (pat_i[j]) mask[idx_i[j*IW +: IW]] = ~mask[idx_i[j*IW +: IW]];
    end
  end

  assign out_o = base_i ^ mask;
endmodule

// File: rtl/sdec_metric.sv
module sdec_metric #(
  parameter int unsigned N  = 32,
  parameter int unsigned Q  = 8,
  parameter int unsigned MW = 13
) (
  input  logic [N-1:0]   cand_i,
  input  logic [N-1:0]   hard_i,
  input  logic [N*Q-1:0] mag_i,
  output logic [MW-1:0]  met_o
);
  always_comb begin
    met_o = '0;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] != hard_i[i]) met_o = met_o + MW'(mag_i[i*Q +: Q]);
    end
  end
endmodule

// File: rtl/sdec_piso.sv
module sdec_piso #(
  parameter int unsigned K = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [K-1:0] din_i,
  output logic         bit_o,
  output logic         vld_o
);
  localparam int LW = $clog2(K + 1);

  logic [K-1:0]  sr_q, sr_d;
  logic [LW-1:0] left_q, left_d;

  always_comb begin
    sr_d   = sr_q;
    left_d = left_q;
    if (load_i) begin
      sr_d   = din_i;
      left_d = LW'(K);
    end else if (left_q != '0) begin
      sr_d   = sr_q >> 1;
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      left_q <= '0;
    end else begin
      sr_q   <= sr_d;
      left_q <= left_d;
    end
  end

  assign bit_o = sr_q[0];
  assign vld_o = (left_q != '0);

  // R9: idle output line carries zero
  a_r9_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_o |-> !bit_o);
endmodule

// File: rtl/dual_list_softdec.sv
module dual_list_softdec #(
  parameter int unsigned K   = sdec_pkg::SD_K,
  parameter int unsigned Q   = sdec_pkg::SD_Q,
  parameter int unsigned NLR = sdec_pkg::SD_NLR,
  parameter int unsigned NST = sdec_pkg::SD_NST
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic [2*K*Q-1:0]             samples_i,
  input  logic [NLR*$clog2(K)-1:0]     sys_lr_i,
  input  logic [NLR*$clog2(K)-1:0]     par_lr_i,
  output logic                         bit_o,
  output logic                         bit_vld_o
);
  localparam int N  = 2 * K;
  localparam int IW = $clog2(K);
  localparam int LW = NLR * IW;
  localparam int MW = Q + $clog2(N);

  // captured frame and search state
  logic [N*Q-1:0] samp_q, samp_d;
  logic [LW-1:0]  slr_q, slr_d, plr_q, plr_d;
  logic           srch_q, srch_d;
  logic [NLR-1:0] cnt_q, cnt_d;
  logic [K-1:0]   best_msg_q, best_msg_d;
  logic [MW-1:0]  best_met_q, best_met_d;

  logic [N-1:0]   hard;
  logic [N*Q-1:0] mag;

  for (genvar i = 0; i < N; i++) begin : g_smp
    assign hard[i]        = samp_q[i*Q + Q-1];
    assign mag[i*Q +: Q]  = hard[i] ? (Q'(0) - samp_q[i*Q +: Q]) : samp_q[i*Q +: Q];
  end

  // systematic branch: flip, re-encode
  logic [K-1:0]  sys_msg, sys_par;
  logic [MW-1:0] met_s;
  sdec_flip #(.K(K), .NLR(NLR), .IW(IW)) u_flip_s (
    .base_i(hard[K-1:0]), .idx_i(slr_q), .pat_i(cnt_q), .out_o(sys_msg));
  sdec_code_map #(.K(K), .NST(NST), .INV(1'b0)) u_enc (
    .in_i(sys_msg), .out_o(sys_par));
  sdec_metric #(.N(N), .Q(Q), .MW(MW)) u_met_s (
    .cand_i({sys_par, sys_msg}), .hard_i(hard), .mag_i(mag), .met_o(met_s));

  // parity branch: flip, invert back to a message
  logic [K-1:0]  par_par, par_msg;
  logic [MW-1:0] met_p;
  sdec_flip #(.K(K), .NLR(NLR), .IW(IW)) u_flip_p (
    .base_i(hard[N-1:K]), .idx_i(plr_q), .pat_i(cnt_q), .out_o(par_par));
  sdec_code_map #(.K(K), .NST(NST), .INV(1'b1)) u_dec (
    .in_i(par_par), .out_o(par_msg));
  sdec_metric #(.N(N), .Q(Q), .MW(MW)) u_met_p (
    .cand_i({par_par, par_msg}), .hard_i(hard), .mag_i(mag), .met_o(met_p));

  // selection and control
  logic          cap_en, last, pick_sys, take;
  logic [K-1:0]  win_msg;
  logic [MW-1:0] win_met;

  always_comb begin
    cap_en   = start_i & ~srch_q;
    last     = srch_q & (&cnt_q);
    pick_sys = (met_s <= met_p);
    win_msg  = pick_sys ? sys_msg : par_msg;
    win_met  = pick_sys ? met_s   : met_p;
    take     = srch_q & ((cnt_q == '0) | (win_met < best_met_q));

    samp_d     = cap_en ? samples_i : samp_q;
    slr_d      = cap_en ? sys_lr_i  : slr_q;
    plr_d      = cap_en ? par_lr_i  : plr_q;
    best_msg_d = take ? win_msg : best_msg_q;
    best_met_d = take ? win_met : best_met_q;
    cnt_d      = cap_en ? '0 : (srch_q ? cnt_q + 1'b1 : cnt_q);
    srch_d     = cap_en | (srch_q & ~last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q     <= '0;
      slr_q      <= '0;
      plr_q      <= '0;
      srch_q     <= 1'b0;
      cnt_q      <= '0;
      best_msg_q <= '0;
      best_met_q <= '0;
    end else begin
      samp_q     <= samp_d;
      slr_q      <= slr_d;
      plr_q      <= plr_d;
      srch_q     <= srch_d;
      cnt_q      <= cnt_d;
      best_msg_q <= best_msg_d;
      best_met_q <= best_met_d;
    end
  end

  sdec_piso #(.K(K)) u_out (
    .clk(clk), .rst_n(rst_n), .load_i(last), .din_i(best_msg_d),
    .bit_o(bit_o), .vld_o(bit_vld_o));

  // R2: a running search keeps its captured frame
  a_r2_frame_held: assert property (@(posedge clk) disable iff (!rst_n)
    srch_q |=> ($stable(samp_q) && $stable(slr_q) && $stable(plr_q)));
  // R3: pattern zero leaves both halves at the hard decision
  a_r3_pattern_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_q && cnt_q == '0) |-> (sys_msg == hard[K-1:0] && par_par == hard[N-1:K]));
  // R6: kept score never rises during a search
  a_r6_best_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_q && cnt_q != '0) |-> (best_met_d <= best_met_q));
  // R8: output window opens as the search closes
  a_r8_out_opens: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(srch_q) |-> bit_vld_o);
endmodule

// File: tb/tb_dual_list_softdec.sv
`timescale 1ns/1ps
module tb_dual_list_softdec;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic [255:0] samples_i;
  logic [19:0]  sys_lr_i, par_lr_i;
  logic         bit_o, bit_vld;

  int total = 0;
  int bad   = 0;

  logic [255:0] nx_s;
  logic [19:0]  nx_sl, nx_pl;

  always #4 clk = ~clk;

  dual_list_softdec dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .samples_i(samples_i),
    .sys_lr_i(sys_lr_i), .par_lr_i(par_lr_i), .bit_o(bit_o), .bit_vld_o(bit_vld));

  // stimulus table: {message, positions sent with wrong sign}
  localparam logic [47:0] VEC [8] = '{
    {16'h0000, 32'h0000_0000},
    {16'hFFFF, 32'h0000_0000},
    {16'hA5C3, 32'h0000_0000},
    {16'h1234, 32'h0000_0009},
    {16'hBEEF, 32'h0004_0000},
    {16'h7F01, 32'h0010_0200},
    {16'h5A5A, 32'h8001_0001},
    {16'hC0DE, 32'h0000_0000}
  };

  function automatic logic [15:0] b_mix(logic [15:0] v);
    logic [15:0] o;
    for (int j = 0; j < 8; j++) begin
      o[2*j]   = v[2*j+1];
      o[2*j+1] = v[2*j] ^ v[2*j+1];
    end
    return o;
  endfunction

  function automatic logic [15:0] b_unmix(logic [15:0] v);
    logic [15:0] o;
    for (int j = 0; j < 8; j++) begin
      o[2*j+1] = v[2*j];
      o[2*j]   = v[2*j] ^ v[2*j+1];
    end
    return o;
  endfunction

  function automatic logic [15:0] b_rot(logic [15:0] v, bit back);
    logic [15:0] o;
    for (int i = 0; i < 16; i++) begin
      int d;
      d = ((i << 1) | (i >> 3)) & 15;
      if (back) o[i] = v[d]; else o[d] = v[i];
    end
    return o;
  endfunction

  function automatic logic [15:0] b_enc(logic [15:0] m);
    logic [15:0] v = m;
    for (int s = 0; s < 3; s++) begin
      v = b_mix(v);
      if (s < 2) v = b_rot(v, 1'b0);
    end
    return v;
  endfunction

  function automatic logic [15:0] b_inv(logic [15:0] p);
    logic [15:0] v = p;
    for (int s = 0; s < 3; s++) begin
      if (s > 0) v = b_rot(v, 1'b1);
      v = b_unmix(v);
    end
    return v;
  endfunction

  function automatic int b_mag(logic [255:0] s, int i);
    logic signed [7:0] v;
    int x;
    v = s[i*8 +: 8];
    x = v;
    return (x < 0) ? -x : x;
  endfunction

  function automatic logic [31:0] b_hard(logic [255:0] s);
    logic [31:0] h;
    for (int i = 0; i < 32; i++) h[i] = s[i*8+7];
    return h;
  endfunction

  function automatic int b_met(logic [31:0] cw, logic [255:0] s);
    logic [31:0] h = b_hard(s);
    int acc = 0;
    for (int i = 0; i < 32; i++) if (cw[i] != h[i]) acc += b_mag(s, i);
    return acc;
  endfunction

  function automatic logic [15:0] b_mask(logic [19:0] lr, int p);
    logic [15:0] m = '0;
    for (int j = 0; j < 5; j++) if (p[j]) m[lr[j*4 +: 4]] = ~m[lr[j*4 +: 4]];
    return m;
  endfunction

  function automatic logic [19:0] b_lr(logic [255:0] s, int h);
    bit used [16];
    logic [19:0] r = '0;
    for (int i = 0; i < 16; i++) used[i] = 1'b0;
    for (int j = 0; j < 5; j++) begin
      int bi, bm;
      bi = 0;
      bm = 1000;
      for (int i = 0; i < 16; i++)
        if (!used[i] && b_mag(s, h*16 + i) < bm) begin bm = b_mag(s, h*16 + i); bi = i; end
      used[bi] = 1'b1;
      r[j*4 +: 4] = 4'(bi);
    end
    return r;
  endfunction

  function automatic logic [15:0] b_model(logic [255:0] s, logic [19:0] sl, logic [19:0] pl);
    logic [31:0] h = b_hard(s);
    logic [15:0] keep = '0;
    int best = 0;
    for (int p = 0; p < 32; p++) begin
      logic [15:0] m1, q2, m2, wm;
      int e1, e2, ew;
      m1 = h[15:0] ^ b_mask(sl, p);
      e1 = b_met({b_enc(m1), m1}, s);
      q2 = h[31:16] ^ b_mask(pl, p);
      m2 = b_inv(q2);
      e2 = b_met({q2, m2}, s);
      if (e1 <= e2) begin wm = m1; ew = e1; end else begin wm = m2; ew = e2; end
      if (p == 0 || ew < best) begin best = ew; keep = wm; end
    end
    return keep;
  endfunction

  function automatic logic [15:0] b_ml(logic [255:0] s);
    logic [15:0] keep = '0;
    int best = 1 << 30;
    for (int m = 0; m < 65536; m++) begin
      int e;
      e = b_met({b_enc(16'(m)), 16'(m)}, s);
      if (e < best) begin best = e; keep = 16'(m); end
    end
    return keep;
  endfunction

  function automatic logic [255:0] b_build(logic [15:0] m, logic [31:0] fl, int seed);
    logic [31:0]  cw = {b_enc(m), m};
    logic [255:0] s = '0;
    for (int i = 0; i < 32; i++) begin
      int mg;
      bit b;
      b = cw[i];
      if (fl[i]) begin b = ~b; mg = 2 + (i % 4); end
      else mg = 20 + ((i*37 + seed) % 90);
      s[i*8 +: 8] = b ? 8'(-mg) : 8'(mg);
    end
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_start(input logic [255:0] s, input logic [19:0] sl, input logic [19:0] pl);
    @(negedge clk);
    samples_i = s; sys_lr_i = sl; par_lr_i = pl; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic collect(input int pre, input bit poke, input bit launch,
                         output logic [15:0] got, output bit tim_ok);
    tim_ok = 1'b1;
    got = '0;
    for (int k = 0; k < pre; k++) begin
      @(negedge clk);
      if (bit_vld) tim_ok = 1'b0;
      if (poke && k == 10) begin start_i = 1'b1; samples_i = ~samples_i; end
      else start_i = 1'b0;
    end
    for (int b = 0; b < 16; b++) begin
      @(negedge clk);
      if (!bit_vld) tim_ok = 1'b0;
      got[b] = bit_o;
      if (launch && b == 0) begin
        samples_i = nx_s; sys_lr_i = nx_sl; par_lr_i = nx_pl; start_i = 1'b1;
      end else start_i = 1'b0;
    end
    @(negedge clk);
    if (bit_vld) tim_ok = 1'b0;
    start_i = 1'b0;
  endtask

  task automatic run_chk(input logic [255:0] s, input logic [19:0] sl, input logic [19:0] pl,
                         input string req);
    logic [15:0] got, exp;
    bit t;
    exp = b_model(s, sl, pl);
    drive_start(s, sl, pl);
    collect(31, 1'b0, 1'b0, got, t);
    chk(t, "R8 output window", 32'(t), 32'd1);
    chk(got == exp, req, 32'(got), 32'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [255:0] s, sa, sb;
    logic [19:0]  sl, pl;
    logic [15:0]  got, exp;
    bit t;

    start_i = 1'b0; samples_i = '0; sys_lr_i = '0; par_lr_i = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(bit_vld == 1'b0, "R9 valid low in reset", 32'(bit_vld), 32'd0);
    chk(bit_o == 1'b0, "R9 line low in reset", 32'(bit_o), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(bit_vld == 1'b0, "R9 valid low after reset", 32'(bit_vld), 32'd0);

    // table walk
    for (int v = 0; v < 8; v++) begin
      logic [15:0] msg;
      logic [31:0] fl;
      msg = VEC[v][47:32];
      fl  = VEC[v][31:0];
      s   = b_build(msg, fl, v * 11);
      sl  = b_lr(s, 0);
      pl  = b_lr(s, 1);
      exp = b_model(s, sl, pl);
      drive_start(s, sl, pl);
      collect(31, 1'b0, 1'b0, got, t);
      chk(t, "R8 output window", 32'(t), 32'd1);
      chk(got == exp, "R3 R4 R6 list search", 32'(got), 32'(exp));
      if (fl == '0) chk(got == msg, "R1 R7 noiseless message", 32'(got), 32'(msg));
      if (v == 2) begin
        exp = b_ml(s);
        chk(got == exp, "R7 exhaustive ML", 32'(got), 32'(exp));
      end
    end

    // R6: unit magnitudes, many equal scores across branches
    s = b_build(16'h3C96, 32'h0810_0002, 0);
    for (int i = 0; i < 32; i++) s[i*8 +: 8] = s[i*8+7] ? 8'hFF : 8'h01;
    run_chk(s, b_lr(s, 0), b_lr(s, 1), "R6 tie preference");
    s = b_build(16'h0F0F, 32'h0300_0300, 0);
    for (int i = 0; i < 32; i++) s[i*8 +: 8] = s[i*8+7] ? 8'hFF : 8'h01;
    run_chk(s, b_lr(s, 0), b_lr(s, 1), "R6 tie preference 2");

    // R5: every magnitude 128, large scores
    s = {32{8'h80}};
    run_chk(s, {4'd0, 4'd15, 4'd11, 4'd7, 4'd3}, {4'd14, 4'd10, 4'd9, 4'd2, 4'd1}, "R5 full scale scores");
    s = b_build(16'h9D2E, 32'h0, 3);
    for (int i = 0; i < 32; i++) s[i*8 +: 8] = s[i*8+7] ? 8'h80 : 8'h7F;
    run_chk(s, {4'd4, 4'd12, 4'd1, 4'd8, 4'd0}, {4'd6, 4'd13, 4'd5, 4'd2, 4'd11}, "R5 mixed full scale");

    // R3: repeated index cancels its flip
    s = b_build(16'h1234, 32'h0000_0009, 33);
    run_chk(s, {4'd7, 4'd6, 4'd5, 4'd2, 4'd2}, b_lr(s, 1), "R3 repeated index");

    // R2: start while searching is ignored
    sa = b_build(16'h7F01, 32'h0010_0200, 55);
    sl = b_lr(sa, 0);
    pl = b_lr(sa, 1);
    exp = b_model(sa, sl, pl);
    drive_start(sa, sl, pl);
    collect(31, 1'b1, 1'b0, got, t);
    chk(t, "R2 R8 window with stray start", 32'(t), 32'd1);
    chk(got == exp, "R2 stray start ignored", 32'(got), 32'(exp));

    // R10: back-to-back frames overlapping the shift out
    sb = b_build(16'hBEEF, 32'h0004_0000, 44);
    nx_s = sb; nx_sl = b_lr(sb, 0); nx_pl = b_lr(sb, 1);
    drive_start(sa, sl, pl);
    collect(31, 1'b0, 1'b1, got, t);
    chk(t, "R10 first window", 32'(t), 32'd1);
    chk(got == exp, "R10 first result", 32'(got), 32'(exp));
    exp = b_model(sb, nx_sl, nx_pl);
    collect(16, 1'b0, 1'b0, got, t);
    chk(t, "R10 second window", 32'(t), 32'd1);
    chk(got == exp, "R10 second result", 32'(got), 32'(exp));
    chk(got == 16'hBEEF, "R10 second message", 32'(got), 32'hBEEF);

    repeat (3) @(negedge clk);
    chk(bit_o == 1'b0 && bit_vld == 1'b0, "R9 idle line", {30'd0, bit_vld, bit_o}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule